// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Alarm Match

This block keeps wall-clock time and a calendar date as packed BCD digit fields and moves them forward by one second each time the `sec_tick` enable is high for a clock cycle. Each word can be replaced from outside with a load strobe, so firmware-facing logic elsewhere can set the clock. Alongside the calendar it keeps a weekday counter and reports whether the current two-digit year is a leap year.

Hours count either 00 to 23 or, in twelve-hour mode, 12, 1, …, 11 with a morning/afternoon flag held in the upper bit of the hour-tens field. On every advance the new time and date are compared with externally held alarm words, and a single-cycle pulse marks the moment the count reaches them.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the time word is 00:00:00 (0x000000), the date word is day 01, month 01, year 00 (0x000101), the weekday is 0 and `alarm_hit` is 0.
- R2: A load strobe replaces its word (time, date or weekday) at the next clock edge; a tick in the same cycle as `time_load` is discarded, and a load of date or weekday wins over a day carry in the same cycle.
- R3: With `sec_tick` and all load strobes low, time, date and weekday hold their values.
- R4: Seconds (bits [6:0]) and minutes (bits [14:8]) count BCD 00 to 59; the ones digit (low nibble) rolls from 9 to 0 and carries into the tens digit, and 59 carries into the next field.
- R5: With `hour24_mode` = 1 the hour field (bits [21:16]) counts 00 to 23; the tick after 23:59:59 gives 00:00:00 and advances the date by one day.
- R6: With `hour24_mode` = 0, bit 21 is the afternoon flag (1 = PM) and bits [20:16] hold the hour 01 to 12; the hour goes 12, 01, …, 11, the step 11:59:59 to 12:00:00 toggles bit 21, and the step from PM to AM advances the date by one day.
- R7: The date word holds day in bits [5:0], month in bits [12:8], year in bits [23:16]; months 04, 06, 09, 11 have 30 days, month 02 has 29 days in a leap year and 28 otherwise, the rest 31; past the last day the day becomes 01 and the month advances, month 12 goes to 01 with the year advanced, and year 99 wraps to 00.
- R8: `leap_year` is 1 exactly when the year value (ten times the tens digit plus the ones digit) is divisible by 4, year 00 included.
- R9: The weekday (0 = Sunday … 6 = Saturday) advances by one at each day carry, 6 wraps to 0, and the reserved code 7 goes to 0.
- R10: `alarm_hit` is high for one cycle, in the same cycle as the advanced time and date appear, when a tick makes the full time word (PM bit included) equal to `alarm_time` and the date word equal to `alarm_date`; a load that produces equality does not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-second advance enable, one cycle wide |
| hour24_mode | input | 1 | 1 = 24-hour counting, 0 = 12-hour counting |
| time_load | input | 1 | Load strobe for the time word |
| time_wdata | input | 22 | BCD time to load |
| date_load | input | 1 | Load strobe for the date word |
| date_wdata | input | 24 | BCD date to load |
| wday_load | input | 1 | Load strobe for the weekday |
| wday_wdata | input | 3 | Weekday to load |
| alarm_time | input | 22 | Alarm time word |
| alarm_date | input | 24 | Alarm date word |
| time_q | output | 22 | Current BCD time |
| date_q | output | 24 | Current BCD date |
| wday_q | output | 3 | Current weekday |
| leap_year | output | 1 | Current year is a leap year |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
A wrong digit or carry inside the time chain shows on `time_q` at the clock edge of the very tick that exercises it, since every field is a register driven straight to the port; a bad month-length or leap decision only shows at a day carry, so the stimulus preloads 23:59:59 on the last day of each month class and checks the date one tick later. A weekday or afternoon-flag fault is visible in the same cycle as the day or half-day carry. An alarm comparison fault shows as a missing or extra `alarm_hit` in the single cycle after the matching tick, so that pulse is sampled in exactly that cycle and in the one after.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

  localparam int TIME_W = 22;
  localparam int DATE_W = 24;
  localparam int WDAY_W = 3;
  localparam int SEXA_W = 7;   // seconds or minutes BCD field
  localparam int HOUR_W = 6;
  localparam logic [WDAY_W-1:0] WDAY_LAST = 3'd6;

  // Advance a 00..59 BCD field; result = {carry, next}
  function automatic logic [SEXA_W:0] sexa_inc(input logic [SEXA_W-1:0] v);
    logic [3:0] ones;
    logic [2:0] tens;
    ones = v[3:0];
    tens = v[6:4];
    if (ones == 4'd9) begin
      if (tens == 3'd5) sexa_inc = {1'b1, 7'h00};
      else              sexa_inc = {1'b0, tens + 3'd1, 4'd0};
    end else begin
      sexa_inc = {1'b0, tens, ones + 4'd1};
    end
  endfunction

  // 24-hour field 00..23; result = {carry, next}
  function automatic logic [HOUR_W:0] hour24_inc(input logic [HOUR_W-1:0] h);
    if (h == 6'h23)          hour24_inc = {1'b1, 6'h00};
    else if (h[3:0] == 4'd9) hour24_inc = {1'b0, h[5:4] + 2'd1, 4'd0};
    else                     hour24_inc = {1'b0, h[5:4], h[3:0] + 4'd1};
  endfunction

  // 12-hour field {pm, tens, ones}; carry on PM -> AM
  function automatic logic [HOUR_W:0] hour12_inc(input logic [HOUR_W-1:0] h);
    logic       pm;
    logic [4:0] hv;
    pm = h[5];
    hv = h[4:0];
    if (hv == 5'h12)          hour12_inc = {1'b0, pm, 5'h01};
    else if (hv == 5'h11)     hour12_inc = {pm, ~pm, 5'h12};
    else if (hv[3:0] == 4'd9) hour12_inc = {1'b0, pm, 5'h10};
    else                      hour12_inc = {1'b0, pm, hv[4], hv[3:0] + 4'd1};
  endfunction

  // Two-digit BCD year divisible by 4
  function automatic logic year_is_leap(input logic [7:0] y);
    if (y[4]) year_is_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      year_is_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // Last day of a month as BCD
  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  endfunction

  // Generic two-digit BCD step with digit tops; wrap handled by caller
  function automatic logic [7:0] bcd2_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd2_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd2_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              load,
  input  logic [TIME_W-1:0] wdata,
  input  logic              hour24,
  output logic [TIME_W-1:0] time_q,
  output logic [TIME_W-1:0] time_d,
  output logic              day_carry
);

  localparam int NSEXA = 2;

  logic [SEXA_W-1:0] sexa_cur [NSEXA];
  logic [SEXA_W-1:0] sexa_nxt [NSEXA];
  logic [NSEXA-1:0]  sexa_cy;

  genvar g;
  generate
    for (g = 0; g < NSEXA; g++) begin : g_sexa
      assign sexa_cur[g] = time_q[g*8 +: SEXA_W];
      assign {sexa_cy[g], sexa_nxt[g]} = sexa_inc(sexa_cur[g]);
    end
  endgenerate

  logic [HOUR_W-1:0] hour_cur, hour_nxt;
  logic              hour_cy;
  logic [SEXA_W-1:0] sec_d, min_d;
  logic [HOUR_W-1:0] hour_d;

  assign hour_cur = time_q[21:16];

  always_comb begin
    if (hour24) {hour_cy, hour_nxt} = hour24_inc(hour_cur);
    else        {hour_cy, hour_nxt} = hour12_inc(hour_cur);
  end

  always_comb begin
    sec_d  = sexa_nxt[0];
    min_d  = sexa_cy[0] ? sexa_nxt[1] : sexa_cur[1];
    hour_d = (sexa_cy[0] && sexa_cy[1]) ? hour_nxt : hour_cur;
  end

  assign day_carry = advance && sexa_cy[0] && sexa_cy[1] && hour_cy;

  always_comb begin
    if (load)         time_d = {wdata[21:16], 1'b0, wdata[14:8], 1'b0, wdata[6:0]};
    else if (advance) time_d = {hour_d, 1'b0, min_d, 1'b0, sec_d};
    else              time_d = time_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
  import rtc_bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_carry,
  input  logic              load,
  input  logic [DATE_W-1:0] wdata,
  output logic [DATE_W-1:0] date_q,
  output logic [DATE_W-1:0] date_d,
  output logic              leap
);

  localparam logic [DATE_W-1:0] DATE_RST = 24'h000101;

  logic [5:0] day_cur, day_nxt;
  logic [4:0] mon_cur, mon_nxt;
  logic [7:0] yr_cur,  yr_nxt;
  logic [7:0] day_step, mon_step;

  assign day_cur  = date_q[5:0];
  assign mon_cur  = date_q[12:8];
  assign yr_cur   = date_q[23:16];
  assign leap     = year_is_leap(yr_cur);
  assign day_step = bcd2_inc({2'b00, day_cur});
  assign mon_step = bcd2_inc({3'b000, mon_cur});

  always_comb begin
    day_nxt = day_cur;
    mon_nxt = mon_cur;
    yr_nxt  = yr_cur;
    if (day_cur == last_day(mon_cur, leap)) begin
      day_nxt = 6'h01;
      if (mon_cur == 5'h12) begin
        mon_nxt = 5'h01;
        yr_nxt  = (yr_cur == 8'h99) ? 8'h00 : bcd2_inc(yr_cur);
      end else begin
        mon_nxt = mon_step[4:0];
      end
    end else begin
      day_nxt = day_step[5:0];
    end
  end

  always_comb begin
    if (load)           date_d = {wdata[23:16], 3'b000, wdata[12:8], 2'b00, wdata[5:0]};
    else if (day_carry) date_d = {yr_nxt, 3'b000, mon_nxt, 2'b00, day_nxt};
    else                date_d = date_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) date_q <= DATE_RST;
    else        date_q <= date_d;
  end

endmodule

// File: rtl/rtc_weekday.sv
module rtc_weekday
  import rtc_bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_carry,
  input  logic              load,
  input  logic [WDAY_W-1:0] wdata,
  output logic [WDAY_W-1:0] wday_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)         wday_q <= '0;
    else if (load)      wday_q <= wdata;
    else if (day_carry) wday_q <= (wday_q >= WDAY_LAST) ? '0 : wday_q + 3'd1;
  end

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              hour24_mode,
  input  logic              time_load,
  input  logic [TIME_W-1:0] time_wdata,
  input  logic              date_load,
  input  logic [DATE_W-1:0] date_wdata,
  input  logic              wday_load,
  input  logic [WDAY_W-1:0] wday_wdata,
  input  logic [TIME_W-1:0] alarm_time,
  input  logic [DATE_W-1:0] alarm_date,
  output logic [TIME_W-1:0] time_q,
  output logic [DATE_W-1:0] date_q,
  output logic [WDAY_W-1:0] wday_q,
  output logic              leap_year,
  output logic              alarm_hit
);

  logic              advance;
  logic              day_roll;
  logic [TIME_W-1:0] time_d;
  logic [DATE_W-1:0] date_d;
  logic              match_d;

  assign advance = sec_tick && !time_load;

  rtc_time_counter u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .load      (time_load),
    .wdata     (time_wdata),
    .hour24    (hour24_mode),
    .time_q    (time_q),
    .time_d    (time_d),
    .day_carry (day_roll)
  );

  rtc_date_counter u_date (
    .clk       (clk),
    .rst_n     (rst_n),
    .day_carry (day_roll),
    .load      (date_load),
    .wdata     (date_wdata),
    .date_q    (date_q),
    .date_d    (date_d),
    .leap      (leap_year)
  );

  rtc_weekday u_wday (
    .clk       (clk),
    .rst_n     (rst_n),
    .day_carry (day_roll),
    .load      (wday_load),
    .wdata     (wday_wdata),
    .wday_q    (wday_q)
  );

  assign match_d = advance && (time_d == alarm_time) && (date_d == alarm_date);

  always_ff @(posedge clk) begin
    if (!rst_n) alarm_hit <= 1'b0;
    else        alarm_hit <= match_d;
  end

endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk
  import rtc_bcd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              time_load,
  input logic [TIME_W-1:0] time_wdata,
  input logic              wday_load,
  input logic [TIME_W-1:0] alarm_time,
  input logic [DATE_W-1:0] alarm_date,
  input logic [TIME_W-1:0] time_q,
  input logic [DATE_W-1:0] date_q,
  input logic [WDAY_W-1:0] wday_q,
  input logic              alarm_hit,
  input logic              advance,
  input logic              day_roll
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |=> time_q == {$past(time_wdata[21:16]), 1'b0, $past(time_wdata[14:8]), 1'b0, $past(time_wdata[6:0])});

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !time_load) |=> $stable(time_q));

  assert_sec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && time_q[3:0] < 4'd9) |=> time_q[3:0] == 4'($past(time_q[3:0]) + 4'd1));

  assert_roll_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |=> time_q[15:0] == 16'h0000);

  assert_wday_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!day_roll && !wday_load) |=> $stable(wday_q));

  assert_wday_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && !wday_load && wday_q < WDAY_LAST) |=> wday_q == 3'($past(wday_q) + 3'd1));

  assert_alarm_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> $past(advance));

  assert_alarm_eq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> (time_q == $past(alarm_time)) && (date_q == $past(alarm_date)));

endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .time_load  (time_load),
  .time_wdata (time_wdata),
  .wday_load  (wday_load),
  .alarm_time (alarm_time),
  .alarm_date (alarm_date),
  .time_q     (time_q),
  .date_q     (date_q),
  .wday_q     (wday_q),
  .alarm_hit  (alarm_hit),
  .advance    (advance),
  .day_roll   (day_roll)
);

// File: tb/rtc_bcd_clock_tb.sv
module rtc_bcd_clock_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        hour24_mode = 1'b1;
  logic        time_load = 1'b0;
  logic [21:0] time_wdata = '0;
  logic        date_load = 1'b0;
  logic [23:0] date_wdata = '0;
  logic        wday_load = 1'b0;
  logic [2:0]  wday_wdata = '0;
  logic [21:0] alarm_time = '0;
  logic [23:0] alarm_date = '0;
  logic [21:0] time_q;
  logic [23:0] date_q;
  logic [2:0]  wday_q;
  logic        leap_year;
  logic        alarm_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_bcd_clock u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hour24_mode(hour24_mode),
    .time_load(time_load), .time_wdata(time_wdata),
    .date_load(date_load), .date_wdata(date_wdata),
    .wday_load(wday_load), .wday_wdata(wday_wdata),
    .alarm_time(alarm_time), .alarm_date(alarm_date),
    .time_q(time_q), .date_q(date_q), .wday_q(wday_q),
    .leap_year(leap_year), .alarm_hit(alarm_hit)
  );

  // {mode, time, date, wday, exp_time, exp_date, exp_wday}
  localparam int NVEC = 16;
  localparam logic [98:0] VEC [NVEC] = '{
    {1'b1, 22'h123456, 24'h250315, 3'd3, 22'h123457, 24'h250315, 3'd3},  // R4
    {1'b1, 22'h000059, 24'h250315, 3'd3, 22'h000100, 24'h250315, 3'd3},  // R4
    {1'b1, 22'h095959, 24'h250315, 3'd3, 22'h100000, 24'h250315, 3'd3},  // R5
    {1'b1, 22'h235959, 24'h240131, 3'd6, 22'h000000, 24'h240201, 3'd0},  // R5 R7 R9
    {1'b1, 22'h235959, 24'h240228, 3'd2, 22'h000000, 24'h240229, 3'd3},  // R7 leap
    {1'b1, 22'h235959, 24'h230228, 3'd2, 22'h000000, 24'h230301, 3'd3},  // R7 common
    {1'b1, 22'h235959, 24'h240229, 3'd4, 22'h000000, 24'h240301, 3'd5},  // R7
    {1'b1, 22'h235959, 24'h991231, 3'd5, 22'h000000, 24'h000101, 3'd6},  // R7 wrap
    {1'b1, 22'h235959, 24'h250430, 3'd1, 22'h000000, 24'h250501, 3'd2},  // R7
    {1'b1, 22'h235959, 24'h250930, 3'd1, 22'h000000, 24'h251001, 3'd2},  // R7
    {1'b1, 22'h235959, 24'h251231, 3'd6, 22'h000000, 24'h260101, 3'd0},  // R7 R9
    {1'b1, 22'h235959, 24'h250331, 3'd7, 22'h000000, 24'h250401, 3'd0},  // R9 code 7
    {1'b0, 22'h115959, 24'h250315, 3'd3, 22'h320000, 24'h250315, 3'd3},  // R6 AM->PM
    {1'b0, 22'h325959, 24'h250315, 3'd3, 22'h210000, 24'h250315, 3'd3},  // R6 12->1
    {1'b0, 22'h315959, 24'h250101, 3'd0, 22'h120000, 24'h250102, 3'd1},  // R6 PM->AM
    {1'b0, 22'h095959, 24'h250315, 3'd3, 22'h100000, 24'h250315, 3'd3}   // R6
  };

  function automatic logic ref_leap(input logic [7:0] y);
    int yv;
    yv = int'(y[7:4]) * 10 + int'(y[3:0]);
    return (yv % 4) == 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive inputs now (at a falling edge), pass one rising edge, return at next falling edge
  task automatic step(input logic tk, input logic tl, input logic [21:0] tw,
                      input logic dl, input logic [23:0] dw,
                      input logic wl, input logic [2:0] ww);
    sec_tick = tk; time_load = tl; time_wdata = tw;
    date_load = dl; date_wdata = dw; wday_load = wl; wday_wdata = ww;
    @(posedge clk);
    @(negedge clk);
    sec_tick = 1'b0; time_load = 1'b0; date_load = 1'b0; wday_load = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hang expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 time", 32'(time_q), 32'h000000);
    check("R1 date", 32'(date_q), 32'h000101);
    check("R1 wday", 32'(wday_q), 32'd0);
    check("R1 alarm", 32'(alarm_hit), 32'd0);
    check("R8 leap year 00", 32'(leap_year), 32'd1);

    // table walk: load, one tick, compare
    for (int i = 0; i < NVEC; i++) begin
      hour24_mode = VEC[i][98];
      step(1'b0, 1'b1, VEC[i][97:76], 1'b1, VEC[i][75:52], 1'b1, VEC[i][51:49]);
      step(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
      check($sformatf("R4/R5/R6 vec%0d time", i), 32'(time_q), 32'(VEC[i][48:27]));
      check($sformatf("R7 vec%0d date", i), 32'(date_q), 32'(VEC[i][26:3]));
      check($sformatf("R9 vec%0d wday", i), 32'(wday_q), 32'(VEC[i][2:0]));
      check($sformatf("R8 vec%0d leap", i), 32'(leap_year), 32'(ref_leap(VEC[i][26:19])));
      check($sformatf("R10 vec%0d no alarm", i), 32'(alarm_hit), 32'd0);
    end

    hour24_mode = 1'b1;

    // R2 tick discarded when time is loaded in the same cycle
    step(1'b1, 1'b1, 22'h081530, 1'b0, '0, 1'b0, '0);
    check("R2 load beats tick", 32'(time_q), 32'h081530);

    // R2 date/weekday load beats a day carry; time still advances
    step(1'b0, 1'b1, 22'h235959, 1'b1, 24'h250706, 1'b1, 3'd2);
    step(1'b1, 1'b0, '0, 1'b1, 24'h250707, 1'b0, '0);
    check("R2 time after carry", 32'(time_q), 32'h000000);
    check("R2 date load beats carry", 32'(date_q), 32'h250707);
    check("R9 weekday takes carry", 32'(wday_q), 32'd3);

    // R3 hold with no tick and no load
    step(1'b0, 1'b1, 22'h142233, 1'b1, 24'h250810, 1'b1, 3'd4);
    repeat (20) step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    check("R3 time hold", 32'(time_q), 32'h142233);
    check("R3 date hold", 32'(date_q), 32'h250810);
    check("R3 wday hold", 32'(wday_q), 32'd4);

    // R10 alarm by counting
    alarm_time = 22'h100005;
    alarm_date = 24'h250610;
    step(1'b0, 1'b1, 22'h100003, 1'b1, 24'h250610, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    check("R10 no hit before match", 32'(alarm_hit), 32'd0);
    step(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    check("R10 hit on match", 32'(alarm_hit), 32'd1);
    check("R10 time at hit", 32'(time_q), 32'h100005);
    step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    check("R10 one-cycle pulse", 32'(alarm_hit), 32'd0);

    // R10 load reaching alarm value gives no pulse
    step(1'b0, 1'b1, 22'h100005, 1'b0, '0, 1'b0, '0);
    check("R10 load no hit", 32'(alarm_hit), 32'd0);

    // R10 date mismatch
    step(1'b0, 1'b1, 22'h100004, 1'b1, 24'h250611, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    check("R10 date mismatch", 32'(alarm_hit), 32'd0);

    // R10 PM bit is part of the comparison in 12-hour mode
    hour24_mode = 1'b0;
    alarm_time = 22'h300005;
    step(1'b0, 1'b1, 22'h100004, 1'b1, 24'h250610, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    check("R10 AM vs PM alarm", 32'(alarm_hit), 32'd0);
    step(1'b0, 1'b1, 22'h300004, 1'b0, '0, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    check("R10 PM alarm hit", 32'(alarm_hit), 32'd1);

    // R8 leap flag for loaded years
    step(1'b0, 1'b0, '0, 1'b1, 24'h960101, 1'b0, '0);
    check("R8 leap 96", 32'(leap_year), 32'(ref_leap(8'h96)));
    step(1'b0, 1'b0, '0, 1'b1, 24'h980101, 1'b0, '0);
    check("R8 leap 98", 32'(leap_year), 32'(ref_leap(8'h98)));

    done = 1'b1;
    finish_run();
  end

endmodule